// File: doc/BRIEF.md
# Debug-Link Instruction Encoder

This block sits between a host-side controller and a byte-wide serial link to a debug port. The host presents one access request at a time: a load or store with direct addressing, a load or store through the target's pointer register, a control/status register access, an unlock key, or a repeat count. The block turns each request into a one-byte opcode followed by its operand bytes and streams them out over a valid/ready byte interface.

For load requests the block then switches to listening. It forwards every byte arriving on the receive side as a response byte and flags the last one. If the link stays silent for too long, it gives up, pulses a timeout flag and is ready for the next request. A repeat request sets how many elements the next direct or indirect load returns. That count is used up by that one load.

Top module: `dbg_link_encoder`

## Requirements
- R1: A direct load (req_kind 0) or direct store (req_kind 1) sends opcode 0x00 or 0x40 respectively, OR'd with req_asize<<2 and req_dsize. Both fields give the byte count minus one. The opcode leaves the block in the cycle after the request is accepted.
- R2: An indirect load (req_kind 2) or indirect store (req_kind 3) sends opcode 0x20 or 0x60 respectively, OR'd with req_pmode<<2 and req_dsize. Pointer modes are 0 `*p`, 1 `*p++`, 2 `p`, 3 `p++`. A store follows the opcode with req_dsize+1 data bytes; a load sends nothing more.
- R3: A control/status load (req_kind 4) sends 0x80|req_csr and then expects one response byte. A control/status store (req_kind 5) sends 0xC0|req_csr followed by req_data[7:0].
- R4: A key request (req_kind 6) sends 0xE0 followed by the 64-bit key parameter (default 0x1289AB45CDD888FF), least significant byte first: FF 88 D8 CD 45 AB 89 12.
- R5: A repeat request (req_kind 7) sends 0xA0|req_dsize followed by req_dsize+1 count bytes from req_data, low byte first. A count of 0x1234 with size 1 gives A1 34 12.
- R6: Every multi-byte operand goes out least significant byte first. A direct store sends its req_asize+1 address bytes before its req_dsize+1 data bytes.
- R7: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_byte does not change.
- R8: After the last opcode/operand byte of a direct or indirect load, the block accepts (N+1)*(req_dsize+1) bytes on rx. N is the stored repeat count. Each byte appears on rsp_byte with rsp_valid in the same cycle, and rsp_last marks the final one.
- R9: While response bytes are still owed, a byte arriving within TIMEOUT_CYC clock edges of the previous event is accepted. When TIMEOUT_CYC edges pass with no byte, rsp_timeout pulses for one cycle and the response phase ends.
- R10: req_ready is low while bytes are being sent or responses are owed. Receive bytes that arrive when no response is owed produce no rsp_valid.
- R11: The repeat count is cleared by the direct or indirect load that uses it, so the following load expects a single element.
- R12: After reset, req_ready is 1, tx_valid, rsp_valid and rsp_timeout are 0, and the repeat count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_kind | input | 3 | Request type (0..7, see R1-R5 tags) |
| req_asize | input | 2 | Address byte count minus one (direct) |
| req_dsize | input | 2 | Data byte count minus one |
| req_pmode | input | 2 | Pointer mode (indirect) |
| req_csr | input | 4 | Control/status register index |
| req_addr | input | 32 | Direct address |
| req_data | input | 32 | Store data or repeat count |
| tx_byte | output | 8 | Byte to link |
| tx_valid | output | 1 | tx_byte valid |
| tx_ready | input | 1 | Link takes tx_byte |
| rx_byte | input | 8 | Byte from link |
| rx_valid | input | 1 | rx_byte valid |
| rsp_byte | output | 8 | Response data |
| rsp_valid | output | 1 | Response byte valid |
| rsp_last | output | 1 | Final response byte |
| rsp_timeout | output | 1 | One-cycle pulse on missing response |

## Verification
The two events that can meet in one cycle are a response byte arriving and the silence counter reaching its limit. The bench counts clock edges from the final transmit handshake of a load. It delivers the byte exactly on the last edge that still counts as in time, and expects rsp_valid with no timeout pulse and a return to idle. A second run delivers no byte at all; it expects the timeout pulse right after that same edge and no earlier, and then checks that a late byte is dropped.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;

  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int KEY_W    = 64;
  localparam int OPER_MAX = KEY_W / 8;          // largest operand run in bytes
  localparam int CNT_W    = DATA_W + 3;         // (repeat+1)*4 fits here

  typedef enum logic [2:0] {
    K_LDD = 3'd0,
    K_STD = 3'd1,
    K_LDI = 3'd2,
    K_STI = 3'd3,
    K_LDC = 3'd4,
    K_STC = 3'd5,
    K_KEY = 3'd6,
    K_RPT = 3'd7
  } req_kind_e;

  localparam logic [7:0] OP_LDD = 8'h00;
  localparam logic [7:0] OP_STD = 8'h40;
  localparam logic [7:0] OP_LDI = 8'h20;
  localparam logic [7:0] OP_STI = 8'h60;
  localparam logic [7:0] OP_LDC = 8'h80;
  localparam logic [7:0] OP_STC = 8'hC0;
  localparam logic [7:0] OP_KEY = 8'hE0;
  localparam logic [7:0] OP_RPT = 8'hA0;

  // keep the low nm1+1 bytes of a word
  function automatic logic [DATA_W-1:0] keep_bytes(input logic [DATA_W-1:0] v,
                                                   input logic [1:0] nm1);
    logic [DATA_W-1:0] m;
    m = {DATA_W{1'b1}} >> (8 * (3 - int'(nm1)));
    return v & m;
  endfunction

  function automatic logic [7:0] make_opcode(input req_kind_e k,
                                             input logic [1:0] asz,
                                             input logic [1:0] dsz,
                                             input logic [1:0] pm,
                                             input logic [3:0] csr);
    logic [7:0] op;
    case (k)
      K_LDD:   op = OP_LDD | {4'h0, asz, dsz};
      K_STD:   op = OP_STD | {4'h0, asz, dsz};
      K_LDI:   op = OP_LDI | {4'h0, pm, dsz};
      K_STI:   op = OP_STI | {4'h0, pm, dsz};
      K_LDC:   op = OP_LDC | {4'h0, csr};
      K_STC:   op = OP_STC | {4'h0, csr};
      K_KEY:   op = OP_KEY;
      default: op = OP_RPT | {6'h0, dsz};
    endcase
    return op;
  endfunction

  // number of operand bytes after the opcode
  function automatic logic [3:0] operand_len(input req_kind_e k,
                                             input logic [1:0] asz,
                                             input logic [1:0] dsz);
    logic [3:0] n;
    case (k)
      K_LDD:   n = 4'(asz) + 4'd1;
      K_STD:   n = 4'(asz) + 4'(dsz) + 4'd2;
      K_LDI:   n = 4'd0;
      K_STI:   n = 4'(dsz) + 4'd1;
      K_LDC:   n = 4'd0;
      K_STC:   n = 4'd1;
      K_KEY:   n = 4'(OPER_MAX);
      default: n = 4'(dsz) + 4'd1;
    endcase
    return n;
  endfunction

  // operand bytes, first-sent byte in bits [7:0]
  function automatic logic [KEY_W-1:0] pack_operands(input req_kind_e k,
                                                     input logic [1:0] asz,
                                                     input logic [1:0] dsz,
                                                     input logic [ADDR_W-1:0] addr,
                                                     input logic [DATA_W-1:0] data,
                                                     input logic [KEY_W-1:0] key);
    logic [KEY_W-1:0] a64, d64, r;
    a64 = {32'h0, keep_bytes(addr, asz)};
    d64 = {32'h0, keep_bytes(data, dsz)};
    case (k)
      K_LDD:   r = a64;
      K_STD:   r = a64 | (d64 << (8 * (int'(asz) + 1)));
      K_STI:   r = d64;
      K_STC:   r = {56'h0, data[7:0]};
      K_KEY:   r = key;
      K_RPT:   r = d64;
      default: r = '0;
    endcase
    return r;
  endfunction

  // response bytes owed after the request is sent
  function automatic logic [CNT_W-1:0] rsp_count(input req_kind_e k,
                                                 input logic [1:0] dsz,
                                                 input logic [DATA_W-1:0] rep);
    logic [CNT_W-1:0] c;
    case (k)
      K_LDD, K_LDI: c = (CNT_W'(rep) + CNT_W'(1)) * CNT_W'(int'(dsz) + 1);
      K_LDC:        c = CNT_W'(1);
      default:      c = '0;
    endcase
    return c;
  endfunction

  function automatic logic is_data_load(input req_kind_e k);
    return (k == K_LDD) || (k == K_LDI);
  endfunction

endpackage

// File: rtl/dbg_op_encoder.sv
module dbg_op_encoder
  import dbg_link_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_VALUE = 64'h1289AB45CDD888FF
) (
  input  logic [2:0]              kind,
  input  logic [1:0]              asize,
  input  logic [1:0]              dsize,
  input  logic [1:0]              pmode,
  input  logic [3:0]              csr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       data,
  input  logic [DATA_W-1:0]       rep_count,
  output logic [8*(OPER_MAX+1)-1:0] frame,
  output logic [3:0]              frame_len,
  output logic [CNT_W-1:0]        rsp_need
);
  req_kind_e k;
  logic [7:0] opc;
  logic [KEY_W-1:0] opers;

  always_comb begin
    k         = req_kind_e'(kind);
    opc       = make_opcode(k, asize, dsize, pmode, csr);
    opers     = pack_operands(k, asize, dsize, addr, data, KEY_VALUE);
    frame     = {opers, opc};
    frame_len = operand_len(k, asize, dsize) + 4'd1;
    rsp_need  = rsp_count(k, dsize, rep_count);
  end
endmodule

// File: rtl/dbg_tx_serializer.sv
module dbg_tx_serializer #(
  parameter int MAX_BYTES = 9,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [8*MAX_BYTES-1:0] load_bytes,
  input  logic [3:0]             load_n,
  input  logic                   tx_ready,
  output logic                   tx_valid,
  output logic [7:0]             tx_byte,
  output logic                   last_hs
);
  logic [8*MAX_BYTES-1:0] shreg;
  logic [CW-1:0]          left;
  logic                   hs;

  assign tx_valid = (left != '0);
  assign tx_byte  = shreg[7:0];
  assign hs       = tx_valid && tx_ready;
  assign last_hs  = hs && (left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= load_bytes;
      left  <= CW'(load_n);
    end else if (hs) begin
      shreg <= shreg >> 8;
      left  <= left - CW'(1);
    end
  end
endmodule

// File: rtl/dbg_rsp_collector.sv
module dbg_rsp_collector #(
  parameter int CNT_W       = 35,
  parameter int TIMEOUT_CYC = 1000,
  localparam int QW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             busy,
  output logic             rsp_valid,
  output logic [7:0]       rsp_byte,
  output logic             rsp_last,
  output logic             rsp_timeout
);
  logic [CNT_W-1:0] owed;
  logic [QW-1:0]    quiet;
  logic             to_q;
  logic             quiet_full;

  assign busy        = (owed != '0);
  assign rsp_valid   = busy && rx_valid;
  assign rsp_byte    = rx_byte;
  assign rsp_last    = rsp_valid && (owed == CNT_W'(1));
  assign quiet_full  = (quiet == QW'(TIMEOUT_CYC - 1));
  assign rsp_timeout = to_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed  <= '0;
      quiet <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= 1'b0;
      if (start) begin
        owed  <= start_cnt;
        quiet <= '0;
      end else if (busy) begin
        if (rx_valid) begin
          owed  <= owed - CNT_W'(1);
          quiet <= '0;
        end else if (quiet_full) begin
          owed  <= '0;
          quiet <= '0;
          to_q  <= 1'b1;
        end else begin
          quiet <= quiet + QW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dbg_link_encoder.sv
module dbg_link_encoder
  import dbg_link_pkg::*;
#(
  parameter logic [63:0] KEY_VALUE   = 64'h1289AB45CDD888FF,
  parameter int          TIMEOUT_CYC = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_kind,
  input  logic [1:0]  req_asize,
  input  logic [1:0]  req_dsize,
  input  logic [1:0]  req_pmode,
  input  logic [3:0]  req_csr,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_data,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_byte,
  input  logic        rx_valid,
  output logic [7:0]  rsp_byte,
  output logic        rsp_valid,
  output logic        rsp_last,
  output logic        rsp_timeout
);
  localparam int FRAME_BYTES = OPER_MAX + 1;

  logic [8*FRAME_BYTES-1:0] frame;
  logic [3:0]               frame_len;
  logic [CNT_W-1:0]         rsp_need;
  logic [CNT_W-1:0]         pend_q;
  logic [DATA_W-1:0]        rep_q;
  logic                     req_fire;
  logic                     ser_last_hs;
  logic                     col_start;
  logic                     col_busy;
  req_kind_e                kind_e;

  assign kind_e    = req_kind_e'(req_kind);
  assign req_ready = !tx_valid && !col_busy;
  assign req_fire  = req_valid && req_ready;
  assign col_start = ser_last_hs && (pend_q != '0);

  dbg_op_encoder #(.KEY_VALUE(KEY_VALUE)) u_enc (
    .kind      (req_kind),
    .asize     (req_asize),
    .dsize     (req_dsize),
    .pmode     (req_pmode),
    .csr       (req_csr),
    .addr      (req_addr),
    .data      (req_data),
    .rep_count (rep_q),
    .frame     (frame),
    .frame_len (frame_len),
    .rsp_need  (rsp_need)
  );

  dbg_tx_serializer #(.MAX_BYTES(FRAME_BYTES)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (req_fire),
    .load_bytes (frame),
    .load_n     (frame_len),
    .tx_ready   (tx_ready),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .last_hs    (ser_last_hs)
  );

  dbg_rsp_collector #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_col (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (col_start),
    .start_cnt   (pend_q),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .busy        (col_busy),
    .rsp_valid   (rsp_valid),
    .rsp_byte    (rsp_byte),
    .rsp_last    (rsp_last),
    .rsp_timeout (rsp_timeout)
  );

  // pending response count and repeat register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      rep_q  <= '0;
    end else if (req_fire) begin
      pend_q <= rsp_need;
      if (kind_e == K_RPT)
        rep_q <= keep_bytes(req_data, req_dsize);
      else if (is_data_load(kind_e))
        rep_q <= '0;
    end
  end
endmodule

// File: rtl/dbg_link_encoder_chk.sv
module dbg_link_encoder_chk #(
  parameter int TIMEOUT_CYC = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_fire,
  input logic       req_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       rx_valid,
  input logic       rsp_valid,
  input logic       rsp_last,
  input logic       rsp_timeout
);
  logic [31:0] silent;

  // consecutive edges spent waiting for a response with nothing received
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      silent <= '0;
    else if (req_ready || tx_valid || rx_valid)
      silent <= '0;
    else if (silent != 32'hFFFF_FFFF)
      silent <= silent + 32'd1;
  end

  assert_opcode_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> tx_valid);

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);

  assert_rsp_needs_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rx_valid && !tx_valid);

  assert_last_is_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  assert_timeout_after_silence_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> silent >= 32'(TIMEOUT_CYC));

  assert_timeout_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |=> !rsp_timeout);

  assert_timeout_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> req_ready);
endmodule

bind dbg_link_encoder dbg_link_encoder_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (.*);

// File: tb/dbg_link_encoder_bench.sv
module dbg_link_encoder_bench;
  localparam int TMO = 12;
  localparam int NV  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [1:0]  req_asize = '0, req_dsize = '0, req_pmode = '0;
  logic [3:0]  req_csr = '0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rsp_byte;
  logic        rsp_valid, rsp_last, rsp_timeout;

  always #10 clk = ~clk;   // 50 MHz

  dbg_link_encoder #(.TIMEOUT_CYC(TMO)) u_dbg_link_encoder (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // kind: 0 LDD 1 STD 2 LDI 3 STI 4 LDC 5 STC 6 KEY 7 RPT
  localparam logic [2:0]  V_KIND [NV] = '{3, 6, 5, 1, 7, 7, 0, 2, 4, 3};
  localparam logic [1:0]  V_ASZ  [NV] = '{0, 0, 0, 1, 0, 0, 3, 0, 0, 0};
  localparam logic [1:0]  V_DSZ  [NV] = '{3, 0, 0, 0, 1, 0, 1, 0, 0, 1};
  localparam logic [1:0]  V_PM   [NV] = '{2, 0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam logic [3:0]  V_CSR  [NV] = '{0, 0, 2, 0, 0, 0, 0, 0, 15, 0};
  localparam logic [31:0] V_ADDR [NV] = '{0, 0, 0, 32'h01CA, 0, 0, 32'h0100_0000, 0, 0, 0};
  localparam logic [31:0] V_DATA [NV] = '{32'h1234_5678, 0, 32'h59, 32'h43, 32'h1234, 0, 0, 0, 0, 32'hBEEF};
  localparam int          V_LEN  [NV] = '{5, 9, 2, 4, 3, 2, 5, 1, 1, 3};
  localparam logic [71:0] V_EXP  [NV] = '{
    72'h12_3456_786B, 72'h1289AB45CDD888FFE0, 72'h59C2, 72'h4301CA44,
    72'h1234A1, 72'h00A0, 72'h01_0000_000D, 72'h24, 72'h8F, 72'hBEEF61};
  localparam int          V_RSP  [NV] = '{0, 0, 0, 0, 0, 0, 2, 1, 1, 0};
  localparam string       V_TAG  [NV] = '{"R2 R6", "R4", "R3", "R1 R6", "R5",
                                          "R5", "R1 R8", "R2 R8", "R3", "R2 R6"};

  // transmit monitor: records each byte as the handshake edge takes it
  logic [71:0] mon_bytes = '0;
  int          mon_n = 0;
  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      mon_bytes[mon_n*8 +: 8] <= tx_byte;
      mon_n <= mon_n + 1;
    end
  end

  // backpressure on the link side
  bit stall_en = 0;
  int stall_ctr = 0;
  always @(negedge clk) begin
    stall_ctr <= stall_ctr + 1;
    tx_ready  <= stall_en ? (stall_ctr % 3 != 1) : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send_req(input logic [2:0] k, input logic [1:0] asz, input logic [1:0] dsz,
                          input logic [1:0] pm, input logic [3:0] csr,
                          input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    mon_bytes = '0;
    mon_n     = 0;
    req_kind = k; req_asize = asz; req_dsize = dsz; req_pmode = pm;
    req_csr = csr; req_addr = a; req_data = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_tx(input int n);
    while (mon_n < n) @(negedge clk);
  endtask

  // feed n response bytes back-to-back and check the forwarded stream
  task automatic feed_rsp(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_byte  = 8'hA0 + 8'(i);
      #1;
      chk(rsp_valid && rsp_byte == rx_byte, tag, "rsp byte",
          {63'h0, rsp_valid, rsp_byte}, {64'h1, rx_byte});
      chk(rsp_last == (i == n - 1), tag, "rsp_last", 72'(rsp_last), 72'(i == n - 1));
      @(negedge clk);
    end
    rx_valid = 1'b0;
    #1;
    chk(req_ready == 1'b1, tag, "idle after response", 72'(req_ready), 72'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(req_ready == 1'b1 && tx_valid == 1'b0 && rsp_valid == 1'b0 && rsp_timeout == 1'b0,
        "R12", "reset outputs", {68'h0, req_ready, tx_valid, rsp_valid, rsp_timeout}, 72'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: repeat count is zero after reset, so a load expects one element
    send_req(3'd2, 2'd0, 2'd0, 2'd1, 4'd0, 32'h0, 32'h0);
    wait_tx(1);
    chk(mon_bytes[7:0] == 8'h24, "R12", "opcode", 72'(mon_bytes[7:0]), 72'h24);
    feed_rsp(1, "R12");

    // table walk with link backpressure
    stall_en = 1;
    for (int v = 0; v < NV; v++) begin
      send_req(V_KIND[v], V_ASZ[v], V_DSZ[v], V_PM[v], V_CSR[v], V_ADDR[v], V_DATA[v]);
      wait_tx(V_LEN[v]);
      chk(mon_bytes == V_EXP[v], V_TAG[v], $sformatf("vector %0d bytes", v), mon_bytes, V_EXP[v]);
      if (V_RSP[v] > 0) feed_rsp(V_RSP[v], V_TAG[v]);
      else begin
        @(negedge clk);
        chk(req_ready && mon_n == V_LEN[v], V_TAG[v], "no extra bytes, idle",
            72'(mon_n), 72'(V_LEN[v]));
      end
    end
    stall_en = 0;
    repeat (2) @(negedge clk);

    // R8: repeat of 2 with two-byte data makes 6 response bytes
    send_req(3'd7, 2'd0, 2'd0, 2'd0, 4'd0, 32'h0, 32'h2);
    wait_tx(2);
    send_req(3'd0, 2'd1, 2'd1, 2'd0, 4'd0, 32'h2000, 32'h0);
    wait_tx(3);
    chk(mon_bytes[23:0] == 24'h200005, "R8", "load frame", 72'(mon_bytes[23:0]), 72'h200005);
    feed_rsp(6, "R8");

    // R11: repeat consumed, next load expects one element of two bytes
    send_req(3'd2, 2'd0, 2'd1, 2'd0, 4'd0, 32'h0, 32'h0);
    wait_tx(1);
    feed_rsp(2, "R11");

    // R10: receive bytes while idle are not forwarded
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h5A;
    #1;
    chk(rsp_valid == 1'b0, "R10", "idle rx ignored", 72'(rsp_valid), 72'h0);
    @(negedge clk);
    rx_valid = 1'b0;

    // R9: no response -> timeout right after edge TMO, not before
    send_req(3'd4, 2'd0, 2'd0, 2'd0, 4'd3, 32'h0, 32'h0);
    while (!(tx_valid && tx_ready)) @(negedge clk);
    @(posedge clk);                          // final transmit handshake
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk);
    chk(rsp_timeout == 1'b0 && req_ready == 1'b0, "R9", "not early",
        {70'h0, rsp_timeout, req_ready}, 72'h0);
    @(negedge clk);
    chk(rsp_timeout == 1'b1 && req_ready == 1'b1, "R9", "timeout pulse",
        {70'h0, rsp_timeout, req_ready}, 72'h3);
    // R10: a late byte after the timeout is dropped
    rx_valid = 1'b1; rx_byte = 8'h77;
    #1;
    chk(rsp_valid == 1'b0, "R10", "late byte ignored", 72'(rsp_valid), 72'h0);
    @(negedge clk);
    rx_valid = 1'b0;
    chk(rsp_timeout == 1'b0, "R9", "single pulse", 72'(rsp_timeout), 72'h0);

    // R9: byte on the last in-time edge wins over the timeout
    send_req(3'd4, 2'd0, 2'd0, 2'd0, 4'd3, 32'h0, 32'h0);
    while (!(tx_valid && tx_ready)) @(negedge clk);
    @(posedge clk);
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'hC3;
    #1;
    chk(rsp_valid && rsp_last && rsp_byte == 8'hC3, "R9", "byte at limit accepted",
        {62'h0, rsp_valid, rsp_last, rsp_byte}, {62'h0, 2'b11, 8'hC3});
    @(negedge clk);
    rx_valid = 1'b0;
    chk(rsp_timeout == 1'b0 && req_ready == 1'b1, "R9", "no timeout, idle",
        {70'h0, rsp_timeout, req_ready}, 72'h1);

    // R7: held byte under stall (port view)
    send_req(3'd6, 2'd0, 2'd0, 2'd0, 4'd0, 32'h0, 32'h0);
    force_stall();
    wait_tx(9);
    chk(mon_bytes == 72'h1289AB45CDD888FFE0, "R7", "key under stall", mon_bytes,
        72'h1289AB45CDD888FFE0);

    finish_run();
  end

  task automatic force_stall();
    stall_en = 1;
    repeat (4) @(negedge clk);
    #1;
    if (tx_valid && !tx_ready) begin
      logic [7:0] held;
      held = tx_byte;
      @(negedge clk);
      #1;
      if (!tx_ready)
        chk(tx_valid && tx_byte == held, "R7", "byte held", 72'(tx_byte), 72'(held));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule